// File: doc/BRIEF.md
# Secure-Gated Interrupt Group Modifier Register Bank

This block holds the per-interrupt group modifier bits of an interrupt distributor, one bit per interrupt ID, packed into 32-bit registers. It sits on a simple memory-mapped register bus. Every bus access carries a non-secure flag. The block keeps a small distributor control word with three fields: a security-disable bit and two affinity-routing enables, one for each security state. From these fields and from the flag on each access it decides whether a modifier register behaves as plain storage, reads as zero and drops writes, or is treated as reserved-zero.

The gating decision depends only on the non-secure flag carried by the access. The state of the requester plays no part, so a secure requester that issues a non-secure access is treated as non-secure. Register index 0 covers interrupt IDs 0 to 31. Those IDs are managed by per-core logic elsewhere, so that register is always reserved-zero here. The stored bits are exported in full to downstream grouping logic, and the export is masked in the same way as reads.

Top module: `grpmod_regs`

## Requirements
- R1: After reset, the control word and all modifier bits are zero, every read returns zero and the exported bits are all zero.
- R2: The control word sits at offset 0x000. Bit 4 is the secure routing enable, bit 5 is the non-secure routing enable and bit 6 is security-disable. All other bits read zero. Secure writes update it, and accesses of either security can read it.
- R3: A non-secure write to the control word leaves it unchanged.
- R4: Modifier register n sits at word-aligned offset 0x0D00 + 4·n, so 0x0D04 selects index 1. With security-disable 0, secure routing 1 and n ≥ 1, a secure access reads back what a secure write stored.
- R5: With security-disable 0, a non-secure access to any modifier register reads zero, and its write is dropped.
- R6: With security-disable 1 or secure routing 0, every modifier register reads zero for either security, writes are dropped, and the exported bits are all zero.
- R7: Modifier register index 0 always reads zero, ignores writes and exports zero.
- R8: Bits stored before a register became reserved-zero are kept. They read back again once the condition clears.
- R9: Offsets that are unaligned, beyond the implemented register count, or outside the modifier window and not the control word read zero, and writes to them change no register.
- R10: Read data appears in the cycle after a read request and is zero in every cycle that does not follow a read.
- R11: Exported slice n equals stored register n when security-disable is 0, secure routing is 1 and n ≥ 1. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_nonsec | input | 1 | Access security attribute, 1 = non-secure |
| bus_rdata | output | 32 | Read data, one cycle after the read request |
| grp_mod_bits | output | NUM_REGS·32 | Masked modifier bits, bit 32·n+k for interrupt ID 32·n+k |

## Verification
The main check sweeps every combination of security-disable, secure routing, access security and register index (0 versus non-zero). A write and a read-back are made for each combination, so the bench can tell the reserved-zero rule apart from the non-secure read-as-zero rule and from the blanking of index 0. A separate pattern hides a register after storing a value, tries to overwrite it while hidden, and then reveals it again. This separates "storage kept but masked" from "storage cleared" and from "write leaked through". Unaligned, out-of-range and out-of-window offsets are tried against a neighbouring live register. Non-secure writes to the control word are tried to show that only secure writes reach it.

// File: rtl/grpmod_pkg.sv
package grpmod_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned OFF_W      = 12;
    localparam int unsigned MAX_REGS   = 32;
    localparam int unsigned BIT_RT_S   = 4;
    localparam int unsigned BIT_RT_NS  = 5;
    localparam int unsigned BIT_SECDIS = 6;

    // window 0x0D00..0x0D7F: offset[11:7] == 5'b11010
    localparam logic [4:0] MOD_WIN_TAG = 5'b11010;

    typedef enum logic [1:0] {
        ACC_NORMAL = 2'd0,
        ACC_RAZWI  = 2'd1,
        ACC_RES0   = 2'd2
    } acc_class_e;

    typedef struct packed {
        logic sec_dis;
        logic route_ns;
        logic route_s;
    } dist_ctrl_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              nonsec;
        logic [OFF_W-1:0]  offset;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Reserved-zero wins over the non-secure filter.
    function automatic acc_class_e classify(dist_ctrl_t c, logic nonsec, logic idx_zero);
        if (c.sec_dis || !c.route_s || idx_zero) return ACC_RES0;
        if (nonsec) return ACC_RAZWI;
        return ACC_NORMAL;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(dist_ctrl_t c);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[BIT_RT_S]   = c.route_s;
        w[BIT_RT_NS]  = c.route_ns;
        w[BIT_SECDIS] = c.sec_dis;
        return w;
    endfunction

    function automatic logic bank_visible(dist_ctrl_t c);
        return !c.sec_dis && c.route_s;
    endfunction

endpackage

// File: rtl/grpmod_decode.sv
module grpmod_decode
    import grpmod_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = 5
) (
    input  logic [OFF_W-1:0] offset,
    output logic             hit_ctrl,
    output logic             hit_mod,
    output logic [IDX_W-1:0] mod_idx,
    output logic             idx_zero
);
    logic       aligned;
    logic       in_window;
    logic [4:0] word;

    always_comb begin
        aligned   = (offset[1:0] == 2'b00);
        in_window = (offset[11:7] == MOD_WIN_TAG);
        word      = offset[6:2];
        hit_ctrl  = aligned && (offset[11:2] == '0);
        hit_mod   = aligned && in_window && (32'(word) < NUM_REGS);
        mod_idx   = word[IDX_W-1:0];
        idx_zero  = (word == 5'd0);
    end
endmodule

// File: rtl/grpmod_ctrl.sv
module grpmod_ctrl
    import grpmod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_nonsec,
    input  logic       hit_ctrl,
    input  logic [2:0] wfield,
    output dist_ctrl_t ctrl
);
    dist_ctrl_t ctrl_q;
    logic       wr_en;

    always_comb wr_en = req_valid && req_write && hit_ctrl && !req_nonsec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.route_s  <= wfield[0];
            ctrl_q.route_ns <= wfield[1];
            ctrl_q.sec_dis  <= wfield[2];
        end
    end

    assign ctrl = ctrl_q;

    assert_ns_ctrl_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && hit_ctrl && req_nonsec) |=> $stable(ctrl_q));
endmodule

// File: rtl/grpmod_bank.sv
module grpmod_bank
    import grpmod_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  dist_ctrl_t                 ctrl,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rd_word,
    output logic [NUM_REGS*DATA_W-1:0] export_bits
);
    logic [DATA_W-1:0] store [NUM_REGS];
    logic              vis;

    always_comb vis = bank_visible(ctrl);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == 0) begin : g_fixed
            // IDs 0..31 are owned by per-core logic: no storage here
            assign store[g] = '0;
        end else begin : g_live
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst) word_q <= '0;
                else if (wr_en && (idx == IDX_W'(g))) word_q <= wdata;
            end
            assign store[g] = word_q;
        end
        assign export_bits[g*DATA_W +: DATA_W] = vis ? store[g] : '0;
    end

    always_comb rd_word = store[idx];

    assert_slice0_export_R7: assert property (@(posedge clk) disable iff (rst)
        export_bits[DATA_W-1:0] == '0);
endmodule

// File: rtl/grpmod_regs.sv
module grpmod_regs
    import grpmod_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [11:0]                bus_offset,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_nonsec,
    output logic [31:0]                bus_rdata,
    output logic [NUM_REGS*32-1:0]     grp_mod_bits
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bus_req_t          req;
    dist_ctrl_t        ctrl;
    logic              hit_ctrl, hit_mod, idx_zero;
    logic [IDX_W-1:0]  mod_idx;
    acc_class_e        acc;
    logic              mod_wr;
    logic [DATA_W-1:0] stored_word;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        req.valid  = bus_valid;
        req.write  = bus_write;
        req.nonsec = bus_nonsec;
        req.offset = bus_offset;
        req.wdata  = bus_wdata;
    end

    grpmod_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_decode (
        .offset   (req.offset),
        .hit_ctrl (hit_ctrl),
        .hit_mod  (hit_mod),
        .mod_idx  (mod_idx),
        .idx_zero (idx_zero)
    );

    grpmod_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req.valid),
        .req_write  (req.write),
        .req_nonsec (req.nonsec),
        .hit_ctrl   (hit_ctrl),
        .wfield     (req.wdata[BIT_SECDIS:BIT_RT_S]),
        .ctrl       (ctrl)
    );

    always_comb begin
        acc    = classify(ctrl, req.nonsec, idx_zero);
        mod_wr = req.valid && req.write && hit_mod && (acc == ACC_NORMAL);
    end

    grpmod_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .wr_en       (mod_wr),
        .idx         (mod_idx),
        .wdata       (req.wdata),
        .rd_word     (stored_word),
        .export_bits (grp_mod_bits)
    );

    always_comb begin
        if (hit_ctrl)                              rd_mux = ctrl_to_word(ctrl);
        else if (hit_mod && (acc == ACC_NORMAL))   rd_mux = stored_word;
        else                                       rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= (req.valid && !req.write) ? rd_mux : '0;
    end

    assign bus_rdata = rdata_q;

    assert_ns_raz_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_nonsec && !ctrl.sec_dis && hit_mod)
        |=> (bus_rdata == '0));

    assert_idx0_raz_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && (bus_offset == 12'hD00)) |=> (bus_rdata == '0));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> (bus_rdata == '0));

    assert_hidden_export_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sec_dis || !ctrl.route_s) |-> (grp_mod_bits == '0));

    assert_unmapped_raz_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !hit_ctrl && !hit_mod) |=> (bus_rdata == '0));
endmodule

// File: tb/grpmod_regs_test.sv
`timescale 1ns/1ps
module grpmod_regs_test;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [11:0]     bus_offset = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_nonsec = 1'b0;
    logic [31:0]     bus_rdata;
    logic [N*32-1:0] grp_mod_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_mem [N];
    logic        m_ds, m_rs;

    grpmod_regs #(.NUM_REGS(N)) uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_nonsec(bus_nonsec),
        .bus_rdata(bus_rdata), .grp_mod_bits(grp_mod_bits)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] off, logic [31:0] d, logic ns);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_offset = off; bus_wdata = d; bus_nonsec = ns;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] off, logic ns, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_offset = off; bus_nonsec = ns;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    function automatic logic [11:0] moff(int i);
        return 12'hD00 + 12'(4 * i);
    endfunction

    function automatic logic vis(int i);
        return !m_ds && m_rs && (i != 0);
    endfunction

    task automatic set_ctrl(logic ds, logic rs);
        bus_wr(12'h000, {25'b0, ds, 1'b1, rs, 4'b0}, 1'b0);
        m_ds = ds; m_rs = rs;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 export after reset", 32'(grp_mod_bits != '0), 32'd0);
        bus_rd(12'h000, 1'b0, d);
        chk("R1 ctrl after reset", d, 32'h0);
        bus_rd(moff(1), 1'b0, d);
        chk("R1 mod read after reset", d, 32'h0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        bus_wr(12'h000, 32'hFFFF_FFFF, 1'b0);
        bus_rd(12'h000, 1'b1, d);
        chk("R2 ctrl fields", d, 32'h0000_0070);
        bus_wr(12'h000, 32'h0, 1'b1);
        bus_rd(12'h000, 1'b0, d);
        chk("R3 ns ctrl write ignored", d, 32'h0000_0070);
        set_ctrl(1'b0, 1'b1);
        bus_rd(12'h000, 1'b0, d);
        chk("R2 ctrl 0x30", d, 32'h0000_0030);
    endtask

    task automatic t_offset;
        logic [31:0] d;
        set_ctrl(1'b0, 1'b1);
        bus_wr(12'hD04, 32'h3FFF_FFFF, 1'b0); m_mem[1] = 32'h3FFF_FFFF;
        bus_rd(12'hD04, 1'b0, d);
        chk("R4 offset 0xD04 index 1", d, 32'h3FFF_FFFF);
        chk("R11 export slice 1", grp_mod_bits[32 +: 32], 32'h3FFF_FFFF);
        bus_wr(moff(N-1), 32'hC0DE_0007, 1'b0); m_mem[N-1] = 32'hC0DE_0007;
        bus_rd(moff(N-1), 1'b0, d);
        chk("R4 last index", d, 32'hC0DE_0007);
        @(negedge clk);
        chk("R10 idle cycle rdata zero", bus_rdata, 32'h0);
    endtask

    task automatic t_matrix;
        logic [31:0] d, pat, exp;
        for (int c = 0; c < 16; c++) begin
            logic ds, rs, ns;
            int   idx;
            ds  = c[0]; rs = c[1]; ns = c[2];
            idx = c[3] ? 3 : 0;
            set_ctrl(ds, rs);
            pat = 32'hA500_0000 | 32'(c * 32'h0101);
            bus_wr(moff(idx), pat, ns);
            if (vis(idx) && !ns) m_mem[idx] = pat;
            bus_rd(moff(idx), ns, d);
            exp = (vis(idx) && !ns) ? m_mem[idx] : 32'h0;
            if (idx == 0)          chk("R7 index0 matrix", d, exp);
            else if (ds || !rs)    chk("R6 res0 matrix", d, exp);
            else if (ns)           chk("R5 ns raz matrix", d, exp);
            else                   chk("R4 normal matrix", d, exp);
            bus_rd(moff(idx), 1'b0, d);
            chk("R5 secure view after matrix write", d, vis(idx) ? m_mem[idx] : 32'h0);
            chk("R11 export slice matrix", grp_mod_bits[idx*32 +: 32],
                vis(idx) ? m_mem[idx] : 32'h0);
            chk("R6 export all zero when hidden", 32'((ds || !rs) && (grp_mod_bits != '0)), 32'd0);
        end
    endtask

    task automatic t_persist;
        logic [31:0] d;
        set_ctrl(1'b0, 1'b1);
        bus_wr(moff(2), 32'h1357_9BDF, 1'b0); m_mem[2] = 32'h1357_9BDF;
        set_ctrl(1'b1, 1'b1);
        bus_wr(moff(2), 32'hDEAD_BEEF, 1'b0);
        bus_rd(moff(2), 1'b0, d);
        chk("R6 hidden by security-disable", d, 32'h0);
        set_ctrl(1'b0, 1'b0);
        bus_wr(moff(2), 32'hDEAD_BEEF, 1'b0);
        bus_rd(moff(2), 1'b0, d);
        chk("R6 hidden by routing off", d, 32'h0);
        set_ctrl(1'b0, 1'b1);
        bus_rd(moff(2), 1'b0, d);
        chk("R8 value reappears", d, 32'h1357_9BDF);
        chk("R8 export reappears", grp_mod_bits[64 +: 32], 32'h1357_9BDF);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        set_ctrl(1'b0, 1'b1);
        bus_wr(moff(1), 32'h5555_AAAA, 1'b0); m_mem[1] = 32'h5555_AAAA;
        bus_wr(12'hD05, 32'hFFFF_0000, 1'b0);
        bus_wr(moff(N), 32'hFFFF_0000, 1'b0);
        bus_wr(12'hD84, 32'hFFFF_0000, 1'b0);
        bus_rd(12'hD05, 1'b0, d);
        chk("R9 unaligned read", d, 32'h0);
        bus_rd(moff(N), 1'b0, d);
        chk("R9 beyond count read", d, 32'h0);
        bus_rd(12'hD84, 1'b0, d);
        chk("R9 outside window read", d, 32'h0);
        bus_rd(moff(1), 1'b0, d);
        chk("R9 neighbour unchanged", d, 32'h5555_AAAA);
        bus_rd(12'h000, 1'b0, d);
        chk("R9 ctrl unchanged", d, 32'h0000_0030);
        for (int i = 0; i < N; i++)
            chk("R9 export unchanged", grp_mod_bits[i*32 +: 32], vis(i) ? m_mem[i] : 32'h0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_mem[i] = '0;
        m_ds = 1'b0; m_rs = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_offset();
        t_matrix();
        t_persist();
        t_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule